// File: doc/BRIEF.md
# Flash Programming Sequencer

This block is the host side of a parallel programming link to a small microcontroller's on-chip flash. The target has no address pins. It keeps its own byte counter, which clears when its reset pin rises and steps forward on each positive pulse of a clock-like advance pin. The sequencer therefore keeps a shadow address in step with that counter. It fetches each byte from a byte source through an address/data pair, programs the byte with high voltage raised, verifies it with high voltage lowered, and pulses the advance pin before the next byte.

A start command latches a byte count, an optional chip-erase request and the end-of-write detection method. The method is either the target's ready/busy line or data polling on bit 7. Every pin step waits a configurable number of clock cycles. The erase strobe width, the write strobe width and the end-of-write timeout are also set in cycles. When the pass ends, the block reports done. If a byte fails to verify or never finishes writing, the block stops early, reports error and holds the failing address.

Top module: `flash_prog_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `busy`, `done` and `error` are 0 and every target pin output (`tgt_rst`, `tgt_hv`, `tgt_prog`, `tgt_adv`, `tgt_data_oe`) is 0, with `tgt_mode` = 4'b0000.
- R2: After `start`, the block holds all target pins low, then raises `tgt_rst` together with `tgt_prog`. `tgt_hv` is never high while `tgt_rst` is low, so the first byte lands at target address 0.
- R3: For each byte, the block sets `tgt_mode` = 4'b0111 and drives the source byte with `tgt_data_oe` = 1. It then raises `tgt_hv` and gives exactly one low pulse on `tgt_prog`, lasting PULSE_CYC cycles.
- R4: With `use_poll` = 0, the block waits for `tgt_rdy` to be 1 before it verifies.
- R5: With `use_poll` = 1, the block waits until `tgt_data_in[7]` equals bit 7 of the byte just written.
- R6: Verification reads with `tgt_hv` = 0 and `tgt_mode` = 4'b0011, and compares all 8 bits of `tgt_data_in` with the source byte.
- R7: After each verified byte, the block gives one high pulse on `tgt_adv` with `tgt_hv` = 0. A successful run of N bytes gives N advance pulses.
- R8: With `erase_en` = 1, one erase runs before the first byte. It sets `tgt_mode` = 4'b1000 with `tgt_hv` = 1 and drives `tgt_prog` low for ERASE_CYC cycles. Mode and high voltage stay steady while the strobe is low, and the erase issues no advance pulse.
- R9: At the end of a pass, `tgt_adv` is low before `tgt_rst` falls. `done` then reads 1 and `busy` reads 0.
- R10: A verify mismatch sets `error` and latches the byte's address on `fail_addr`. No further write strobes follow.
- R11: If the end of write is not seen within TMO_CYC cycles, the block sets `error` and latches the address on `fail_addr`.
- R12: A byte count of 0 writes nothing and still ends with `done`. A count above 2^ADDR_W is clamped to 2^ADDR_W bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a pass; accepted only when idle |
| erase_en | input | 1 | Run a chip erase before programming |
| use_poll | input | 1 | 1: data polling, 0: ready/busy for end of write |
| byte_count | input | ADDR_W+1 | Number of bytes to program |
| src_addr | output | ADDR_W | Address requested from the byte source |
| src_data | input | 8 | Byte at `src_addr` |
| tgt_rst | output | 1 | Target reset / programming enable level |
| tgt_hv | output | 1 | Request for the high programming voltage on the reset pin |
| tgt_prog | output | 1 | Program strobe, active-low pulse |
| tgt_adv | output | 1 | Target address advance pulse |
| tgt_mode | output | 4 | Mode select lines |
| tgt_data_out | output | 8 | Data driven to the target |
| tgt_data_oe | output | 1 | Output enable for `tgt_data_out` |
| tgt_rdy | input | 1 | Target ready (1) / busy (0) |
| tgt_data_in | input | 8 | Data read from the target |
| busy | output | 1 | Pass in progress |
| done | output | 1 | Last pass finished |
| error | output | 1 | Last pass failed |
| fail_addr | output | ADDR_W | Address of the failing byte |

## Verification
The bench builds the block with ADDR_W = 11, SETUP_CYC = 2, PULSE_CYC = 3, ERASE_CYC = 20 and TMO_CYC = 40. The short delays keep each byte to a couple of dozen cycles. A full 2048-byte pass, which the clamp row reaches from a count of 4095, therefore fits easily. The 40-cycle timeout lets a hung write end within a few dozen cycles, while staying well above the model's 8-cycle busy time.

// File: rtl/fps_pkg.sv
package fps_pkg;

  localparam logic [3:0] MODE_IDLE  = 4'b0000;
  localparam logic [3:0] MODE_WRITE = 4'b0111;
  localparam logic [3:0] MODE_READ  = 4'b0011;
  localparam logic [3:0] MODE_ERASE = 4'b1000;

  typedef enum logic [4:0] {
    S_IDLE, S_INIT, S_RST_HI,
    S_ER_MODE, S_ER_HV, S_ER_PULSE, S_ER_REL, S_ER_HVDN,
    S_WR_SETUP, S_WR_HV, S_WR_PULSE, S_WR_REL,
    S_RD_HVDN, S_WAIT_END, S_VERIFY,
    S_ADV_HI, S_ADV_LO, S_FIN_ADV, S_FIN_RST
  } state_t;

  typedef struct packed {
    logic       rst;
    logic       hv;
    logic       prog;
    logic       adv;
    logic       oe;
    logic [3:0] mode;
  } pins_t;

  // Pin levels held by the target interface in each state
  function automatic pins_t pins_of(state_t s);
    pins_t p;
    p = '{rst: 1'b1, hv: 1'b0, prog: 1'b1, adv: 1'b0, oe: 1'b0, mode: MODE_IDLE};
    case (s)
      S_IDLE, S_INIT, S_FIN_RST: begin p.rst = 1'b0; p.prog = 1'b0; end
      S_ER_MODE, S_ER_HVDN:      p.mode = MODE_ERASE;
      S_ER_HV, S_ER_REL:         begin p.mode = MODE_ERASE; p.hv = 1'b1; end
      S_ER_PULSE:                begin p.mode = MODE_ERASE; p.hv = 1'b1; p.prog = 1'b0; end
      S_WR_SETUP:                begin p.mode = MODE_WRITE; p.oe = 1'b1; end
      S_WR_HV, S_WR_REL:         begin p.mode = MODE_WRITE; p.oe = 1'b1; p.hv = 1'b1; end
      S_WR_PULSE:                begin p.mode = MODE_WRITE; p.oe = 1'b1; p.hv = 1'b1; p.prog = 1'b0; end
      S_RD_HVDN, S_WAIT_END, S_VERIFY, S_ADV_LO: p.mode = MODE_READ;
      S_ADV_HI:                  begin p.mode = MODE_READ; p.adv = 1'b1; end
      default:                   ;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/fps_step_timer.sv
module fps_step_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/fps_addr_track.sv
module fps_addr_track #(
  parameter int ADDR_W = 11,
  localparam int CNT_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [CNT_W-1:0]  count_in,
  input  logic              inc,
  output logic [ADDR_W-1:0] addr,
  output logic              reached
);
  localparam logic [CNT_W-1:0] DEPTH = CNT_W'(1) << ADDR_W;

  logic [CNT_W-1:0] addr_q;
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      count_q <= '0;
    end else if (clr) begin
      addr_q  <= '0;
      count_q <= (count_in > DEPTH) ? DEPTH : count_in;
    end else if (inc) begin
      addr_q  <= addr_q + 1'b1;
    end
  end

  assign addr    = addr_q[ADDR_W-1:0];
  assign reached = (addr_q == count_q);

  AST_ADDR_WITHIN_COUNT: assert property (@(posedge clk) disable iff (rst)
    addr_q <= count_q); // R7
  AST_COUNT_CLAMPED: assert property (@(posedge clk) disable iff (rst)
    count_q <= DEPTH); // R12
endmodule

// File: rtl/fps_byte_cmp.sv
module fps_byte_cmp #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] expect_b,
  input  logic [DATA_W-1:0] got_b,
  output logic              full_match,
  output logic              poll_match
);
  assign full_match = (expect_b == got_b);
  assign poll_match = (expect_b[DATA_W-1] == got_b[DATA_W-1]);
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import fps_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int SETUP_CYC = 25,
  parameter int PULSE_CYC = 50,
  parameter int ERASE_CYC = 500000,
  parameter int TMO_CYC   = 250000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                erase_en,
  input  logic                use_poll,
  input  logic [ADDR_W:0]     byte_count,
  output logic [ADDR_W-1:0]   src_addr,
  input  logic [7:0]          src_data,
  output logic                tgt_rst,
  output logic                tgt_hv,
  output logic                tgt_prog,
  output logic                tgt_adv,
  output logic [3:0]          tgt_mode,
  output logic [7:0]          tgt_data_out,
  output logic                tgt_data_oe,
  input  logic                tgt_rdy,
  input  logic [7:0]          tgt_data_in,
  output logic                busy,
  output logic                done,
  output logic                error,
  output logic [ADDR_W-1:0]   fail_addr
);
  localparam int MAX_AB = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int MAX_CD = (ERASE_CYC > TMO_CYC) ? ERASE_CYC : TMO_CYC;
  localparam int MAXD   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int TMR_W  = $clog2(MAXD) + 1;

  state_t           state, state_n;
  pins_t            pins_q;
  logic             tmr_load, tmr_exp;
  logic [TMR_W-1:0] tmr_val;
  logic             erase_q, poll_q;
  logic [7:0]       data_q;
  logic             reached, inc, accept, fail_evt;
  logic             full_match, poll_match, end_seen;
  logic [ADDR_W-1:0] cur_addr;

  assign accept = (state == S_IDLE) && start;
  assign inc    = (state == S_VERIFY) && (state_n == S_ADV_HI);

  fps_step_timer #(.W(TMR_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
  );

  fps_addr_track #(.ADDR_W(ADDR_W)) u_track (
    .clk(clk), .rst(rst), .clr(accept), .count_in(byte_count),
    .inc(inc), .addr(cur_addr), .reached(reached)
  );

  fps_byte_cmp #(.DATA_W(8)) u_cmp (
    .expect_b(data_q), .got_b(tgt_data_in),
    .full_match(full_match), .poll_match(poll_match)
  );

  assign end_seen = poll_q ? poll_match : tgt_rdy;

  always_comb begin
    state_n  = state;
    fail_evt = 1'b0;
    case (state)
      S_IDLE:     if (start) state_n = S_INIT;
      S_INIT:     if (tmr_exp) state_n = S_RST_HI;
      S_RST_HI:   if (tmr_exp) state_n = erase_q ? S_ER_MODE : (reached ? S_FIN_ADV : S_WR_SETUP);
      S_ER_MODE:  if (tmr_exp) state_n = S_ER_HV;
      S_ER_HV:    if (tmr_exp) state_n = S_ER_PULSE;
      S_ER_PULSE: if (tmr_exp) state_n = S_ER_REL;
      S_ER_REL:   if (tmr_exp) state_n = S_ER_HVDN;
      S_ER_HVDN:  if (tmr_exp) state_n = reached ? S_FIN_ADV : S_WR_SETUP;
      S_WR_SETUP: if (tmr_exp) state_n = S_WR_HV;
      S_WR_HV:    if (tmr_exp) state_n = S_WR_PULSE;
      S_WR_PULSE: if (tmr_exp) state_n = S_WR_REL;
      S_WR_REL:   if (tmr_exp) state_n = S_RD_HVDN;
      S_RD_HVDN:  if (tmr_exp) state_n = S_WAIT_END;
      S_WAIT_END: begin
        if (end_seen) state_n = S_VERIFY;
        else if (tmr_exp) begin
          state_n  = S_FIN_ADV;
          fail_evt = 1'b1;
        end
      end
      S_VERIFY: begin
        if (tmr_exp) begin
          if (full_match) state_n = S_ADV_HI;
          else begin
            state_n  = S_FIN_ADV;
            fail_evt = 1'b1;
          end
        end
      end
      S_ADV_HI:   if (tmr_exp) state_n = S_ADV_LO;
      S_ADV_LO:   if (tmr_exp) state_n = reached ? S_FIN_ADV : S_WR_SETUP;
      S_FIN_ADV:  if (tmr_exp) state_n = S_FIN_RST;
      S_FIN_RST:  if (tmr_exp) state_n = S_IDLE;
      default:    state_n = S_IDLE;
    endcase
  end

  always_comb begin
    tmr_load = (state_n != state);
    case (state_n)
      S_ER_PULSE: tmr_val = TMR_W'(ERASE_CYC - 1);
      S_WR_PULSE: tmr_val = TMR_W'(PULSE_CYC - 1);
      S_WAIT_END: tmr_val = TMR_W'(TMO_CYC - 1);
      default:    tmr_val = TMR_W'(SETUP_CYC - 1);
    endcase
  end

  function automatic logic in_byte_span(state_t s);
    return (s == S_WR_SETUP) || (s == S_WR_HV) || (s == S_WR_PULSE) || (s == S_WR_REL) ||
           (s == S_RD_HVDN) || (s == S_WAIT_END) || (s == S_VERIFY);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      pins_q    <= pins_of(S_IDLE);
      busy      <= 1'b0;
      done      <= 1'b0;
      error     <= 1'b0;
      fail_addr <= '0;
      erase_q   <= 1'b0;
      poll_q    <= 1'b0;
      data_q    <= '0;
    end else begin
      state  <= state_n;
      pins_q <= pins_of(state_n);
      busy   <= (state_n != S_IDLE);
      if (!in_byte_span(state)) data_q <= src_data;
      if (accept) begin
        erase_q <= erase_en;
        poll_q  <= use_poll;
        done    <= 1'b0;
        error   <= 1'b0;
      end
      if (fail_evt) begin
        error     <= 1'b1;
        fail_addr <= cur_addr;
      end
      if (state == S_FIN_RST && state_n == S_IDLE) done <= 1'b1;
    end
  end

  assign src_addr     = cur_addr;
  assign tgt_rst      = pins_q.rst;
  assign tgt_hv       = pins_q.hv;
  assign tgt_prog     = pins_q.prog;
  assign tgt_adv      = pins_q.adv;
  assign tgt_data_oe  = pins_q.oe;
  assign tgt_mode     = pins_q.mode;
  assign tgt_data_out = data_q;

  AST_HV_NEEDS_RST: assert property (@(posedge clk) disable iff (rst)
    tgt_hv |-> tgt_rst); // R2
  AST_DRIVE_ONLY_WRITE: assert property (@(posedge clk) disable iff (rst)
    tgt_data_oe |-> (tgt_mode == MODE_WRITE)); // R3
  AST_ADV_HV_LOW: assert property (@(posedge clk) disable iff (rst)
    tgt_adv |-> (!tgt_hv && !tgt_data_oe)); // R7
  AST_STROBE_HOLDS_MODE: assert property (@(posedge clk) disable iff (rst)
    (tgt_rst && !tgt_prog && $past(tgt_rst && !tgt_prog)) |-> ($stable(tgt_mode) && $stable(tgt_hv))); // R8
  AST_ADV_LOW_AT_RST_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(tgt_rst) |-> !$past(tgt_adv)); // R9
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R9
  AST_READ_HV_LOW: assert property (@(posedge clk) disable iff (rst)
    (tgt_mode == MODE_READ) |-> !tgt_hv); // R6
  AST_ERR_SETS_ONCE_BUSY: assert property (@(posedge clk) disable iff (rst)
    $rose(error) |-> busy); // R10
endmodule

// File: tb/flash_prog_seq_tb_top.sv
module flash_prog_seq_tb_top;
  localparam int ADDR_W = 11;
  localparam int SETUP  = 2;
  localparam int PULSE  = 3;
  localparam int ERASE  = 20;
  localparam int TMO    = 40;
  localparam int BUSYL  = 8;
  localparam int NROWS  = 7;

  // Row: count[31:20] erase[19] poll[18] blank[17] fault[16:15] faddr[14:4] exp_err[3]
  localparam logic [31:0] ROWS [NROWS] = '{
    {12'd8,    1'b0, 1'b0, 1'b1, 2'd0, 11'd0, 1'b0, 3'd0},
    {12'd5,    1'b1, 1'b1, 1'b0, 2'd0, 11'd0, 1'b0, 3'd0},
    {12'd6,    1'b0, 1'b0, 1'b1, 2'd1, 11'd3, 1'b1, 3'd0},
    {12'd4,    1'b0, 1'b1, 1'b1, 2'd2, 11'd2, 1'b1, 3'd0},
    {12'd0,    1'b0, 1'b0, 1'b1, 2'd0, 11'd0, 1'b0, 3'd0},
    {12'd1,    1'b1, 1'b0, 1'b0, 2'd0, 11'd0, 1'b0, 3'd0},
    {12'd4095, 1'b0, 1'b1, 1'b1, 2'd0, 11'd0, 1'b0, 3'd0}
  };

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, erase_en = 1'b0, use_poll = 1'b0;
  logic [ADDR_W:0]   byte_count = '0;
  logic [ADDR_W-1:0] src_addr, fail_addr;
  logic [7:0]        src_data, tgt_data_out;
  logic tgt_rst, tgt_hv, tgt_prog, tgt_adv, tgt_data_oe, busy, done, error;
  logic [3:0] tgt_mode;
  logic       tgt_rdy = 1'b1;
  logic [7:0] tgt_din = 8'h00;

  int total = 0, bad = 0, cyc = 0, seed = 0;

  always #10 clk = ~clk;

  function automatic logic [7:0] pat(int s, int a);
    return 8'(((a * 37) + (s * 91) + (a >> 4)) ^ 8'h5A);
  endfunction

  assign src_data = pat(seed, int'(src_addr));

  flash_prog_seq #(.ADDR_W(ADDR_W), .SETUP_CYC(SETUP), .PULSE_CYC(PULSE),
                   .ERASE_CYC(ERASE), .TMO_CYC(TMO)) dut_i (
    .clk(clk), .rst(rst), .start(start), .erase_en(erase_en), .use_poll(use_poll),
    .byte_count(byte_count), .src_addr(src_addr), .src_data(src_data),
    .tgt_rst(tgt_rst), .tgt_hv(tgt_hv), .tgt_prog(tgt_prog), .tgt_adv(tgt_adv),
    .tgt_mode(tgt_mode), .tgt_data_out(tgt_data_out), .tgt_data_oe(tgt_data_oe),
    .tgt_rdy(tgt_rdy), .tgt_data_in(tgt_din), .busy(busy), .done(done),
    .error(error), .fail_addr(fail_addr)
  );

  // Target model, evaluated away from the active edge
  logic [7:0]  tmem [2048];
  logic [11:0] tcnt = '0;
  logic [7:0]  last_wr = '0;
  logic p_rst = 0, p_hv = 0, p_prog = 0, p_adv = 0;
  int busy_c = 0, low_len = 0, viol = 0, wr_n = 0, adv_n = 0, er_n = 0, er_w = 0;
  bit busy_inf = 0;
  int hang_addr = -1, bad_addr = -1;

  always @(negedge clk) begin
    if (tgt_rst && !p_rst) tcnt = '0;
    if (tgt_hv && !p_hv && !tgt_rst) viol++;
    if (tgt_adv && !p_adv) begin
      adv_n++;
      if (tgt_hv) viol++;
      tcnt = tcnt + 1'b1;
    end
    if (!tgt_rst && p_rst && p_adv) viol++;
    if (busy_c > 0) busy_c--;
    if (tgt_rst && !tgt_prog) low_len++;
    if (tgt_rst && tgt_prog && !p_prog) begin
      if (tgt_hv && tgt_mode == 4'b0111) begin
        wr_n++;
        if (!tgt_data_oe || tgt_data_out != pat(seed, int'(tcnt[10:0]))) viol++;
        if (low_len != PULSE) viol++;
        tmem[tcnt[10:0]] = tmem[tcnt[10:0]] & tgt_data_out;
        last_wr = tgt_data_out;
        busy_c = BUSYL;
        if (int'(tcnt) == hang_addr) busy_inf = 1;
      end else if (tgt_hv && tgt_mode == 4'b1000) begin
        er_n++;
        er_w = low_len;
        if (adv_n != 0) viol++;
        if (low_len >= ERASE) for (int i = 0; i < 2048; i++) tmem[i] = 8'hFF;
      end
    end
    if (!tgt_rst || tgt_prog) low_len = 0;
    p_rst = tgt_rst; p_hv = tgt_hv; p_prog = tgt_prog; p_adv = tgt_adv;
    tgt_rdy = !((busy_c > 0) || busy_inf);
    if (tgt_rst && !tgt_hv && tgt_mode == 4'b0011) begin
      if ((busy_c > 0) || busy_inf) tgt_din = {~last_wr[7], 7'h00};
      else if (int'(tcnt) == bad_addr) tgt_din = tmem[tcnt[10:0]] ^ 8'h04;
      else tgt_din = tmem[tcnt[10:0]];
    end else tgt_din = 8'h00;
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 2048; i++) tmem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 pins", {tgt_rst, tgt_hv, tgt_prog, tgt_adv, tgt_data_oe}, 0);
    chk("R1 status", {busy, done, error}, 0);
    chk("R1 mode", tgt_mode, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", {busy, tgt_rst, tgt_prog}, 0);

    for (int r = 0; r < NROWS; r++) begin
      logic [31:0] v;
      int cnt, n, fa, ew, eb, fault;
      v = ROWS[r];
      cnt = int'(v[31:20]);
      fault = int'(v[16:15]);
      fa = int'(v[14:4]);
      seed = r;
      if (v[17]) for (int i = 0; i < 2048; i++) tmem[i] = 8'hFF;
      hang_addr = (fault == 2) ? fa : -1;
      bad_addr  = (fault == 1) ? fa : -1;
      busy_inf = 0; busy_c = 0;
      viol = 0; wr_n = 0; adv_n = 0; er_n = 0; er_w = 0;
      byte_count = v[31:20]; erase_en = v[19]; use_poll = v[18];
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n = 0;
      while (busy && n < 60000) begin @(negedge clk); n++; end
      eb = (cnt > 2048) ? 2048 : cnt;
      ew = v[3] ? fa + 1 : eb;
      // R9, R10, R11: completion status
      chk($sformatf("R9 done row%0d", r), done, 1);
      chk($sformatf("R10 R11 error row%0d", r), error, int'(v[3]));
      if (v[3]) chk($sformatf("R10 R11 fail_addr row%0d", r), fail_addr, fa);
      // R3, R12: strobe count; R7: advance count
      chk($sformatf("R3 R12 writes row%0d", r), wr_n, ew);
      chk($sformatf("R7 advances row%0d", r), adv_n, v[3] ? fa : eb);
      // R2, R3, R7, R9: protocol ordering seen by the target model
      chk($sformatf("R2 protocol row%0d", r), viol, 0);
      chk($sformatf("R9 pins low row%0d", r), {tgt_rst, tgt_adv, tgt_hv}, 0);
      // R8: erase pulse
      chk($sformatf("R8 erase count row%0d", r), er_n, int'(v[19]));
      if (v[19]) chk($sformatf("R8 erase width row%0d", r), er_w, ERASE);
      if (!v[3]) begin
        int mm;
        mm = 0;
        for (int a = 0; a < eb; a++) if (tmem[a] != pat(r, a)) mm++;
        // R4, R5, R6: bytes landed and verified in both end-of-write modes
        chk($sformatf("R4 R5 R6 contents row%0d", r), mm, 0);
      end
    end

    // R1: reset in the middle of a pass
    for (int i = 0; i < 2048; i++) tmem[i] = 8'hFF;
    hang_addr = -1; bad_addr = -1;
    byte_count = 12'd8; erase_en = 1'b0; use_poll = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (30) @(negedge clk);
    chk("R1 mid-run busy", busy, 1);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid-run pins", {tgt_rst, tgt_hv, tgt_prog, tgt_adv, tgt_data_oe}, 0);
    chk("R1 mid-run status", {busy, done, error}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 stays idle", busy, 0);
    finish_run();
  end
endmodule